// File: doc/BRIEF.md
# Hamming ECC syndrome corrector

This block decides what to do with a 512-byte data sector once its 3-byte Hamming code has been recomputed. The caller presents the code stored in the spare area and the code recomputed over the sector, together with a flag that says whether an erased (all-ones) stored code stands for an unprogrammed page. It does this with a one-cycle start pulse.

The block XORs the two codes into a 24-bit syndrome and sorts it into one of four outcomes:

- clean;
- a single data-bit error that can be repaired;
- a fault confined to the stored code;
- damage that cannot be repaired.

For a repairable error it works out which byte of the sector holds the flipped bit and which bit it is. It then repairs the byte in place with one read cycle and one write cycle on a byte-wide sector buffer port. The buffer has a synchronous read. The block signals the end of the job with a one-cycle done pulse, and it holds the status code and the error position until the next accepted start.

The controller is a four-state machine:

- IDLE waits for start.
- FETCH reads the faulty byte.
- PATCH writes the byte back with the bit inverted.
- REPORT pulses done.

Its transitions are:

- IDLE to FETCH on start when a repair is needed.
- IDLE to REPORT on start when no data change is needed.
- FETCH to PATCH always.
- PATCH to REPORT always.
- REPORT to IDLE always.
- IDLE holds while start is low.

Top module: `hamming_sector_fixer`

## Requirements
- R1: With a zero syndrome, status is 0 (clean), the buffer is not touched, and done is high in the cycle after the clock edge that samples start.
- R2: When the stored code is FF FF FF and ignore_unset is 1, status is 0 whatever the recomputed code is. With ignore_unset at 0, the same codes are decoded normally.
- R3: In a correctable syndrome, each of the three syndrome bytes has bit 1 different from bit 0, bit 3 different from bit 2, bit 5 different from bit 4, and bit 7 different from bit 6. Such a syndrome gives status 1 (corrected). Syndrome byte k is code bits 8k+7 down to 8k.
- R4: For a correctable syndrome, bit_idx bits 2, 1 and 0 are syndrome byte 2 bits 7, 5 and 3.
- R5: For a correctable syndrome, byte_idx bit 8 is syndrome byte 2 bit 1. byte_idx bits 7 to 4 are syndrome byte 1 bits 7, 5, 3 and 1. byte_idx bits 3 to 0 are syndrome byte 0 bits 7, 5, 3 and 1.
- R6: For a correctable syndrome, the block reads address byte_idx for one cycle. In the next cycle it writes the returned byte XOR (1 << bit_idx) to the same address. Done follows one cycle after the write, three cycles after the start edge.
- R7: A syndrome that is not correctable and has exactly one of its 24 bits set gives status 2 (code-only fault). There is no buffer write, and done comes one cycle after start.
- R8: Every other nonzero syndrome gives status 3 (uncorrectable). There is no buffer write, and done comes one cycle after start.
- R9: A start that arrives while a job is in FETCH, PATCH or REPORT is ignored. It produces no extra done, no buffer access and no status change.
- R10: After reset, done, buf_rd_en and buf_wr_en are low and status is 0. byte_idx and bit_idx are 0 whenever status is not 1.
- R11: status, byte_idx and bit_idx hold their values from done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to evaluate the codes |
| stored_code | input | 24 | Code read from the spare area (byte k at bits 8k+7:8k) |
| calc_code | input | 24 | Code recomputed over the sector |
| ignore_unset | input | 1 | Treat an all-ones stored code as an unprogrammed page |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 clean, 1 corrected, 2 code-only fault, 3 uncorrectable |
| byte_idx | output | 9 | Faulty byte position |
| bit_idx | output | 3 | Faulty bit position |
| buf_rd_en | output | 1 | Sector buffer read strobe |
| buf_wr_en | output | 1 | Sector buffer write strobe |
| buf_addr | output | 9 | Sector buffer address |
| buf_wdata | output | 8 | Repaired byte |
| buf_rdata | input | 8 | Buffer read data, valid the cycle after buf_rd_en |

## Verification
Two things can land on the same cycle: a fresh start request and the controller's own completion (done pulse), or a fresh start and the buffer read or write of a repair still in progress. The bench provokes this by holding start high with an uncorrectable code pair through the FETCH, PATCH and REPORT cycles of a repair. It then judges that exactly one write and one done occurred, that the reported status stayed at corrected, and that no late done appears afterwards.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 3;
    localparam int CODE_W  = LANE_W * LANES;
    localparam int IDX_W   = 9;
    localparam int SEL_W   = $clog2(LANE_W);
    localparam logic [LANE_W-1:0] PAIR_LOW = 8'h55;

    typedef enum logic [1:0] {
        FIX_CLEAN     = 2'd0,
        FIX_DONE      = 2'd1,
        FIX_CODE_ONLY = 2'd2,
        FIX_FATAL     = 2'd3
    } fix_status_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_FETCH  = 2'd1,
        S_PATCH  = 2'd2,
        S_REPORT = 2'd3
    } fsm_state_t;

    typedef struct packed {
        fix_status_t       status;
        logic              repair;
        logic [IDX_W-1:0]  byte_idx;
        logic [SEL_W-1:0]  bit_idx;
    } verdict_t;
endpackage

// File: rtl/hsf_classify.sv
module hsf_classify
    import hsf_pkg::*;
(
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    input  logic              ignore_unset,
    output verdict_t          verdict
);
    logic [CODE_W-1:0] syn;
    logic [LANES-1:0]  lane_ok;
    logic              erased;
    logic              lone_bit;

    assign syn      = stored_code ^ calc_code;
    assign erased   = &stored_code;
    assign lone_bit = $onehot(syn);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane;
        assign lane       = syn[g*LANE_W +: LANE_W];
        assign lane_ok[g] = ((lane ^ (lane >> 1)) & PAIR_LOW) == PAIR_LOW;
    end

    always_comb begin
        verdict          = '0;
        verdict.status   = FIX_CLEAN;
        if (syn == '0) begin
            verdict.status = FIX_CLEAN;
        end else if (erased && ignore_unset) begin
            verdict.status = FIX_CLEAN;
        end else if (&lane_ok) begin
            verdict.status   = FIX_DONE;
            verdict.repair   = 1'b1;
            verdict.bit_idx  = {syn[23], syn[21], syn[19]};
            verdict.byte_idx = {syn[17],
                                syn[15], syn[13], syn[11], syn[9],
                                syn[7],  syn[5],  syn[3],  syn[1]};
        end else if (lone_bit) begin
            verdict.status = FIX_CODE_ONLY;
        end else begin
            verdict.status = FIX_FATAL;
        end
    end
endmodule

// File: rtl/hsf_sequencer.sv
module hsf_sequencer
    import hsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  verdict_t          verdict,
    input  logic [LANE_W-1:0] buf_rdata,
    output logic              done,
    output logic [1:0]        status,
    output logic [IDX_W-1:0]  byte_idx,
    output logic [SEL_W-1:0]  bit_idx,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [IDX_W-1:0]  buf_addr,
    output logic [LANE_W-1:0] buf_wdata
);
    fsm_state_t state_q, state_d;
    verdict_t   held_q;
    logic       accept;

    assign accept = (state_q == S_IDLE) && start;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = verdict.repair ? S_FETCH : S_REPORT;
            S_FETCH:  state_d = S_PATCH;
            S_PATCH:  state_d = S_REPORT;
            S_REPORT: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      held_q <= '0;
        else if (accept) held_q <= verdict;
    end

    always_comb begin
        done      = (state_q == S_REPORT);
        buf_rd_en = (state_q == S_FETCH);
        buf_wr_en = (state_q == S_PATCH);
        buf_addr  = held_q.byte_idx;
        buf_wdata = buf_rdata ^ (LANE_W'(1) << held_q.bit_idx);
        status    = held_q.status;
        byte_idx  = held_q.byte_idx;
        bit_idx   = held_q.bit_idx;
    end
endmodule

// File: rtl/hamming_sector_fixer.sv
module hamming_sector_fixer
    import hsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] stored_code,
    input  logic [CODE_W-1:0] calc_code,
    input  logic              ignore_unset,
    output logic              done,
    output logic [1:0]        status,
    output logic [IDX_W-1:0]  byte_idx,
    output logic [SEL_W-1:0]  bit_idx,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [IDX_W-1:0]  buf_addr,
    output logic [LANE_W-1:0] buf_wdata,
    input  logic [LANE_W-1:0] buf_rdata
);
    verdict_t verdict;

    hsf_classify u_classify (
        .stored_code (stored_code),
        .calc_code   (calc_code),
        .ignore_unset(ignore_unset),
        .verdict     (verdict)
    );

    hsf_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .verdict  (verdict),
        .buf_rdata(buf_rdata),
        .done     (done),
        .status   (status),
        .byte_idx (byte_idx),
        .bit_idx  (bit_idx),
        .buf_rd_en(buf_rd_en),
        .buf_wr_en(buf_wr_en),
        .buf_addr (buf_addr),
        .buf_wdata(buf_wdata)
    );
endmodule

// File: rtl/hsf_checker.sv
module hsf_checker
    import hsf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic [1:0]       status,
    input logic [IDX_W-1:0] byte_idx,
    input logic [SEL_W-1:0] bit_idx,
    input logic             buf_rd_en,
    input logic             buf_wr_en,
    input logic [IDX_W-1:0] buf_addr
);
    assert_read_then_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> buf_wr_en);

    assert_done_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |=> done);

    assert_write_has_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $past(buf_rd_en));

    assert_addr_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $stable(buf_addr));

    assert_one_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_rd_en, buf_wr_en, done}));

    assert_no_write_unless_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'd1) |-> !$past(buf_wr_en));

    assert_idx_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'd1) |-> (byte_idx == '0 && bit_idx == '0));

    assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr_en || done) |=> $stable(status));
endmodule

bind hamming_sector_fixer hsf_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .status   (status),
    .byte_idx (byte_idx),
    .bit_idx  (bit_idx),
    .buf_rd_en(buf_rd_en),
    .buf_wr_en(buf_wr_en),
    .buf_addr (buf_addr)
);

// File: tb/hamming_sector_fixer_test.sv
module hamming_sector_fixer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code = '0;
    logic        ignore_unset = 1'b0;
    logic        done;
    logic [1:0]  status;
    logic [8:0]  byte_idx;
    logic [2:0]  bit_idx;
    logic        buf_rd_en, buf_wr_en;
    logic [8:0]  buf_addr;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata;

    logic [7:0]  mem [512];
    logic [7:0]  exp_mem [512];
    int          n_checks = 0;
    int          n_errors = 0;
    int          n_writes = 0;
    int          n_reads = 0;
    int          n_dones = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    hamming_sector_fixer uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stored_code(stored_code), .calc_code(calc_code),
        .ignore_unset(ignore_unset), .done(done), .status(status),
        .byte_idx(byte_idx), .bit_idx(bit_idx),
        .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    function automatic logic [7:0] init_byte(int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= init_byte(i);
            buf_rdata <= '0;
        end else begin
            if (buf_rd_en) buf_rdata <= mem[buf_addr];
            if (buf_wr_en) mem[buf_addr] <= buf_wdata;
            if (buf_wr_en) n_writes <= n_writes + 1;
            if (buf_rd_en) n_reads <= n_reads + 1;
            if (done) n_dones <= n_dones + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Build a syndrome that encodes byte b, bit k per the R4/R5 layout.
    function automatic logic [23:0] make_syn(logic [8:0] b, logic [2:0] k);
        logic [23:0] s;
        logic [11:0] hi;
        hi = {k[2], k[1], k[0], b[8], b[7], b[6], b[5], b[4], b[3], b[2], b[1], b[0]};
        for (int p = 0; p < 12; p++) begin
            s[2*p+1] = hi[p];
            s[2*p]   = ~hi[p];
        end
        return s;
    endfunction

    function automatic void model(input logic [23:0] st, input logic [23:0] ca,
                                  input logic ign, output int stat,
                                  output int eb, output int ek);
        logic [23:0] s;
        int pairs_ok;
        int ones;
        s = st ^ ca;
        eb = 0; ek = 0;
        pairs_ok = 0;
        ones = 0;
        for (int p = 0; p < 12; p++) if (s[2*p] != s[2*p+1]) pairs_ok++;
        for (int i = 0; i < 24; i++) if (s[i]) ones++;
        if (s == 0 || (st == 24'hFFFFFF && ign)) stat = 0;
        else if (pairs_ok == 12) begin
            stat = 1;
            ek = {s[23], s[21], s[19]};
            eb = {s[17], s[15], s[13], s[11], s[9], s[7], s[5], s[3], s[1]};
        end else if (ones == 1) stat = 2;
        else stat = 3;
    endfunction

    task automatic run(input logic [23:0] st, input logic [23:0] ca, input logic ign);
        int es, eb, ek, lat, w0, elat;
        bit same;
        string tg;
        model(st, ca, ign, es, eb, ek);
        tg = (es == 0) ? ((st == 24'hFFFFFF) ? "R2" : "R1") :
             (es == 1) ? "R3" : (es == 2) ? "R7" : "R8";
        w0 = n_writes;
        @(negedge clk);
        stored_code = st; calc_code = ca; ignore_unset = ign; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        elat = (es == 1) ? 3 : 1;
        chk(lat == elat, (es == 1) ? "R6 latency" : "R1/R7 latency", lat, elat);
        chk(int'(status) == es, tg, status, es);
        chk(int'(byte_idx) == eb, (es == 1) ? "R5" : "R10", byte_idx, eb);
        chk(int'(bit_idx) == ek, (es == 1) ? "R4" : "R10", bit_idx, ek);
        if (es == 1) exp_mem[eb] = exp_mem[eb] ^ (8'd1 << ek);
        chk(n_writes - w0 == ((es == 1) ? 1 : 0), "R6/R7 write count", n_writes - w0,
            (es == 1) ? 1 : 0);
        same = 1'b1;
        for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) same = 1'b0;
        chk(same, "R6 buffer contents", same, 1);
        @(negedge clk);
        chk(!done && int'(status) == es, "R11 hold", status, es);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] st, syn;
        int d0, w0, r0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 512; i++) exp_mem[i] = init_byte(i);
        repeat (3) @(negedge clk);
        chk(done == 0 && buf_rd_en == 0 && buf_wr_en == 0, "R10 reset strobes",
            {done, buf_rd_en, buf_wr_en}, 0);
        chk(status == 0, "R10 reset status", status, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        run(24'h3C_A5_17, 24'h3C_A5_17, 1'b0);                      // R1 clean
        run(24'hFFFFFF, 24'h123456, 1'b1);                          // R2 erased, ignored
        run(24'hFFFFFF, 24'hFFFFFF ^ make_syn(9'd77, 3'd5), 1'b0);  // R2 flag off decodes
        run(24'h010203, 24'h010203 ^ make_syn(9'd0, 3'd0), 1'b0);   // R5 lowest byte
        run(24'h999999, 24'h999999 ^ make_syn(9'd511, 3'd7), 1'b0); // R5 highest byte
        run(24'h55AA00, 24'h55AA00 ^ 24'h000100, 1'b0);             // R7 one bit
        run(24'h55AA00, 24'h55AA00 ^ 24'h800000, 1'b0);             // R7 top bit
        run(24'h55AA00, 24'h55AA00 ^ 24'h000003, 1'b0);             // R8 two bits
        run(24'h000000, 24'h000000 ^ make_syn(9'd256, 3'd2) ^ 24'h1, 1'b0); // R8 broken pair

        // R9: start held through FETCH, PATCH and REPORT with uncorrectable codes
        d0 = n_dones; w0 = n_writes; r0 = n_reads;
        @(negedge clk);
        stored_code = 24'h0F0F0F; calc_code = 24'h0F0F0F ^ make_syn(9'd300, 3'd6);
        ignore_unset = 1'b0; start = 1'b1;
        @(negedge clk);
        calc_code = 24'h0F0F0F ^ 24'h000011;
        repeat (3) @(negedge clk);
        start = 1'b0;
        exp_mem[300] = exp_mem[300] ^ 8'h40;
        repeat (4) @(negedge clk);
        chk(n_dones - d0 == 1, "R9 done count", n_dones - d0, 1);
        chk(n_writes - w0 == 1 && n_reads - r0 == 1, "R9 access count", n_writes - w0, 1);
        chk(status == 2'd1 && byte_idx == 9'd300, "R9 status kept", status, 1);
        chk(mem[300] == exp_mem[300], "R9 patched byte", mem[300], exp_mem[300]);

        // Constrained random
        for (int n = 0; n < 60; n++) begin
            int kind;
            kind = $urandom % 4;
            st = 24'($urandom);
            if ($urandom % 8 == 0) st = 24'hFFFFFF;
            case (kind)
                0: syn = '0;
                1: syn = make_syn(9'($urandom), 3'($urandom));
                2: syn = 24'h1 << ($urandom % 24);
                default: syn = 24'($urandom);
            endcase
            run(st, st ^ syn, 1'($urandom));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule